// File: doc/BRIEF.md
# Byte-Wide SPI Port with Master and Slave Roles

This block is a full-duplex serial peripheral port that moves one byte at a time. A small register interface exposes three locations: a control register, a status register and a data register. In the master role, a write to the data register starts a local SCK generator. The byte shifts out on MOSI while the reply shifts in from MISO, and the generator stops after the eighth bit. In the slave role, an external master supplies SCK and an active-low select. The port then shifts out the byte that was last written to the data register and captures what arrives on MOSI.

Clock polarity, clock phase and bit order can each be set, so the port works with any of the four usual SPI timing modes and with either bit order. In the master role, four divider settings set the SCK rate. A completion flag and a collision flag report the result of each transfer. The completion flag, gated by an enable bit, drives a single interrupt line. The slave-side inputs pass through a synchronizer, so an external SCK must run several times slower than the system clock.

Top module: `spi_port`

## Requirements
- R1: In the master role (control bit0 = 1 enable, bit1 = 1 master), a data-register write while idle starts a transfer. SCK makes exactly 8 cycles and then stops. Status bit7 (done) is then set, and the received byte can be read from the data register (address 2).
- R2: Control bit2 (polarity) is the SCK idle level. With control bit3 (phase) = 0, the first bit is on the data line before the first SCK edge and is sampled on the odd-numbered edges. With phase = 1, data changes on the odd-numbered edges and is sampled on the even-numbered edges.
- R3: Control bit4 = 1 shifts the LSB first in both directions. Control bit4 = 0 shifts the MSB first.
- R4: Control bits 6:5 select the master SCK period: 0, 1, 2 and 3 give 4, 16, 64 and 128 system clocks.
- R5: A data-register write while a transfer is in progress sets status bit6 (collision). The byte being shifted is left unchanged.
- R6: While the select input is high in the slave role, the MISO output enable is low and the bit position returns to the start. A partial byte sets no flag and is discarded.
- R7: irq is high exactly when the done flag is set and control bit7 is 1. The collision flag never raises irq.
- R8: Both flags clear when a status read that saw a flag set is followed by a data-register access. A data access that no such status read preceded leaves the flags set.
- R9: Register map: address 0 is control, address 1 is status and address 2 is data. All registers read 0 after reset.
- R10: With control bit0 = 0, the SCK, MOSI and MISO output enables stay low, and a data write starts no transfer.
- R11: In the slave role with the select input low, the port shifts on the external SCK. It drives the loaded byte on MISO and sets the done flag after 8 bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 2 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data (combinational) |
| irq | output | 1 | Interrupt request |
| sck_o | output | 1 | Master SCK |
| sck_oe | output | 1 | SCK output enable |
| mosi_o | output | 1 | Master serial out |
| mosi_oe | output | 1 | MOSI output enable |
| miso_i | input | 1 | Master serial in |
| sck_i | input | 1 | Slave SCK in |
| ss_n_i | input | 1 | Slave select, active low |
| mosi_i | input | 1 | Slave serial in |
| miso_o | output | 1 | Slave serial out |
| miso_oe | output | 1 | MISO output enable |

## Verification
A wrong bit counter appears at once as an SCK burst with the wrong number of cycles or as a shifted received byte, within one transfer. A wrong phase or order setting corrupts the byte seen at the far end of the very first transfer. A flag that is set or cleared wrongly shows on the next status read or on irq. A select input that fails to reset the bit position shows as a misaligned byte on the first full transfer after a partial one.

// File: rtl/spi_port_pkg.sv
package spi_port_pkg;

  typedef struct packed {
    logic       ien;
    logic [1:0] rate;
    logic       lsb;
    logic       cpha;
    logic       cpol;
    logic       master;
    logic       en;
  } ctrl_t;

  localparam logic [1:0] ADDR_CTRL = 2'd0;
  localparam logic [1:0] ADDR_STAT = 2'd1;
  localparam logic [1:0] ADDR_DATA = 2'd2;

  // system clocks per SCK half period for each rate code
  function automatic int unsigned half_cycles(input logic [1:0] sel);
    case (sel)
      2'd0:    return 2;
      2'd1:    return 8;
      2'd2:    return 32;
      default: return 64;
    endcase
  endfunction

endpackage

// File: rtl/spi_port_sync.sv
module spi_port_sync #(
  parameter int STAGES = 2,
  parameter int WIDTH  = 3,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  localparam int CHAIN_W = STAGES * WIDTH;

  logic [CHAIN_W-1:0] chain_q, chain_d;

  always_comb chain_d = {chain_q[CHAIN_W-WIDTH-1:0], d};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= {STAGES{RST_VAL}};
    else        chain_q <= chain_d;
  end

  assign q = chain_q[CHAIN_W-1 -: WIDTH];
endmodule

// File: rtl/spi_port_rate.sv
module spi_port_rate #(
  parameter int CNT_W = 7
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       run,
  input  logic [1:0] sel,
  output logic       tick
);
  import spi_port_pkg::*;

  logic [CNT_W-1:0] cnt_q, cnt_d, limit;

  always_comb begin
    limit = CNT_W'(half_cycles(sel) - 1);
    if (!run)               cnt_d = '0;
    else if (cnt_q == limit) cnt_d = '0;
    else                    cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign tick = run && (cnt_q == limit);
endmodule

// File: rtl/spi_port_core.sv
module spi_port_core #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         active,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         edge_ev,
  input  logic         cpha,
  input  logic         lsb_first,
  input  logic         in_bit,
  output logic         out_bit,
  output logic         done,
  output logic         mid,
  output logic [W-1:0] shreg
);
  localparam int IDX_W = $clog2(2 * W);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(2 * W - 1);

  logic [W-1:0]     sr_q, sr_d, shifted;
  logic [IDX_W-1:0] idx_q, idx_d;
  logic             rxb_q, rxb_d, dout_q, dout_d, done_q, done_d;
  logic             lead, trail, sr_out, ins;

  always_comb begin
    lead    = edge_ev && !idx_q[0];
    trail   = edge_ev &&  idx_q[0];
    sr_out  = lsb_first ? sr_q[0] : sr_q[W-1];
    ins     = cpha ? in_bit : rxb_q;
    shifted = lsb_first ? {ins, sr_q[W-1:1]} : {sr_q[W-2:0], ins};

    sr_d   = sr_q;
    idx_d  = idx_q;
    rxb_d  = rxb_q;
    dout_d = dout_q;
    done_d = 1'b0;
    if (load) begin
      sr_d  = load_val;
      idx_d = '0;
    end else if (!active) begin
      idx_d = '0;
    end else if (edge_ev) begin
      idx_d = idx_q + 1'b1;
      if (lead) begin
        rxb_d  = in_bit;
        dout_d = sr_out;
      end
      if (trail) begin
        sr_d   = shifted;
        done_d = (idx_q == LAST);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr_q   <= '0;
      idx_q  <= '0;
      rxb_q  <= 1'b0;
      dout_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      sr_q   <= sr_d;
      idx_q  <= idx_d;
      rxb_q  <= rxb_d;
      dout_q <= dout_d;
      done_q <= done_d;
    end
  end

  assign out_bit = cpha ? dout_q : sr_out;
  assign done    = done_q;
  assign mid     = (idx_q != '0);
  assign shreg   = sr_q;
endmodule

// File: rtl/spi_port.sv
module spi_port #(
  parameter int XFER_W      = 8,
  parameter int SYNC_STAGES = 2,
  parameter int RATE_CNT_W  = 7
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       bus_wr,
  input  logic       bus_rd,
  input  logic [1:0] bus_addr,
  input  logic [7:0] bus_wdata,
  output logic [7:0] bus_rdata,
  output logic       irq,
  output logic       sck_o,
  output logic       sck_oe,
  output logic       mosi_o,
  output logic       mosi_oe,
  input  logic       miso_i,
  input  logic       sck_i,
  input  logic       ss_n_i,
  input  logic       mosi_i,
  output logic       miso_o,
  output logic       miso_oe
);
  import spi_port_pkg::*;

  // reset: asserted asynchronously, released on a clock edge
  logic [1:0] rst_pipe;
  logic       rst_n_int;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_n_int = rst_pipe[1];

  logic [7:0]        ctrl_q, ctrl_d, rxbuf_q, rxbuf_d;
  ctrl_t             ctrl;
  logic              spif_q, spif_d, wcol_q, wcol_d, armed_q, armed_d;
  logic              run_q, run_d, sck_q, sck_d, sck_prev_q, sck_prev_d;
  logic              sck_s, ss_s, mosi_s;
  logic              tick, master_mode, slave_act, busy;
  logic              acc_data, data_wr, stat_rd, collide, load, start;
  logic              edge_ev, core_active, in_bit;
  logic              core_out, core_done, core_mid;
  logic [XFER_W-1:0] core_sr;

  spi_port_sync #(.STAGES(SYNC_STAGES), .WIDTH(3), .RST_VAL(3'b010)) u_sync (
    .clk(clk), .rst_n(rst_n_int),
    .d({sck_i, ss_n_i, mosi_i}),
    .q({sck_s, ss_s, mosi_s})
  );

  spi_port_rate #(.CNT_W(RATE_CNT_W)) u_rate (
    .clk(clk), .rst_n(rst_n_int), .run(run_q), .sel(ctrl.rate), .tick(tick)
  );

  spi_port_core #(.W(XFER_W)) u_core (
    .clk(clk), .rst_n(rst_n_int), .active(core_active), .load(load),
    .load_val(bus_wdata[XFER_W-1:0]), .edge_ev(edge_ev), .cpha(ctrl.cpha),
    .lsb_first(ctrl.lsb), .in_bit(in_bit), .out_bit(core_out),
    .done(core_done), .mid(core_mid), .shreg(core_sr)
  );

  always_comb begin
    ctrl        = ctrl_t'(ctrl_q);
    master_mode = ctrl.en && ctrl.master;
    slave_act   = ctrl.en && !ctrl.master && !ss_s;
    busy        = run_q || core_mid;
    acc_data    = (bus_wr || bus_rd) && (bus_addr == ADDR_DATA);
    data_wr     = bus_wr && (bus_addr == ADDR_DATA);
    stat_rd     = bus_rd && (bus_addr == ADDR_STAT);
    collide     = data_wr && busy;
    load        = data_wr && !busy;
    start       = load && master_mode;
    edge_ev     = master_mode ? tick : (slave_act && (sck_s ^ sck_prev_q));
    core_active = master_mode ? run_q : slave_act;
    in_bit      = master_mode ? miso_i : mosi_s;

    ctrl_d = ctrl_q;
    if (bus_wr && (bus_addr == ADDR_CTRL)) ctrl_d = bus_wdata;

    if (!master_mode)   run_d = 1'b0;
    else if (start)     run_d = 1'b1;
    else if (core_done) run_d = 1'b0;
    else                run_d = run_q;

    spif_d  = spif_q;
    wcol_d  = wcol_q;
    armed_d = armed_q;
    if (acc_data && armed_q) begin
      spif_d  = 1'b0;
      wcol_d  = 1'b0;
      armed_d = 1'b0;
    end
    if (stat_rd && (spif_q || wcol_q)) armed_d = 1'b1;
    if (core_done) spif_d = 1'b1;
    if (collide)   wcol_d = 1'b1;

    rxbuf_d    = core_done ? 8'(core_sr) : rxbuf_q;
    sck_d      = !run_q ? ctrl.cpol : (tick ? !sck_q : sck_q);
    sck_prev_d = sck_s;
  end

  always_ff @(posedge clk or negedge rst_n_int) begin
    if (!rst_n_int) begin
      ctrl_q     <= '0;
      rxbuf_q    <= '0;
      spif_q     <= 1'b0;
      wcol_q     <= 1'b0;
      armed_q    <= 1'b0;
      run_q      <= 1'b0;
      sck_q      <= 1'b0;
      sck_prev_q <= 1'b0;
    end else begin
      ctrl_q     <= ctrl_d;
      rxbuf_q    <= rxbuf_d;
      spif_q     <= spif_d;
      wcol_q     <= wcol_d;
      armed_q    <= armed_d;
      run_q      <= run_d;
      sck_q      <= sck_d;
      sck_prev_q <= sck_prev_d;
    end
  end

  always_comb begin
    case (bus_addr)
      ADDR_CTRL: bus_rdata = ctrl_q;
      ADDR_STAT: bus_rdata = {spif_q, wcol_q, 6'b0};
      ADDR_DATA: bus_rdata = rxbuf_q;
      default:   bus_rdata = 8'h00;
    endcase
  end

  assign irq     = spif_q && ctrl.ien;
  assign sck_o   = sck_q;
  assign sck_oe  = master_mode;
  assign mosi_o  = core_out;
  assign mosi_oe = master_mode;
  assign miso_o  = core_out;
  assign miso_oe = slave_act;
endmodule

// File: rtl/spi_port_chk.sv
module spi_port_chk (
  input logic       clk,
  input logic       rst_ni,
  input logic       bus_wr,
  input logic [1:0] bus_addr,
  input logic       run_q,
  input logic       wcol_q,
  input logic       spif_q,
  input logic       core_done,
  input logic       core_active,
  input logic       core_mid,
  input logic       sck_o,
  input logic [7:0] ctrl_q
);
  a_r1_flag_from_engine: assert property (@(posedge clk) disable iff (!rst_ni)
    $rose(spif_q) |-> $past(core_done));

  a_r1_clock_stops_on_done: assert property (@(posedge clk) disable iff (!rst_ni)
    $fell(run_q) |-> ($past(core_done) || !$past(ctrl_q[0]) || !$past(ctrl_q[1])));

  a_r2_start_at_idle_level: assert property (@(posedge clk) disable iff (!rst_ni)
    $rose(run_q) |-> (sck_o == ctrl_q[2]));

  a_r5_collision_flagged: assert property (@(posedge clk) disable iff (!rst_ni)
    (bus_wr && (bus_addr == 2'd2) && run_q) |=> wcol_q);

  a_r6_deselect_rewinds: assert property (@(posedge clk) disable iff (!rst_ni)
    !core_active |=> !core_mid);
endmodule

bind spi_port spi_port_chk u_chk (
  .clk(clk), .rst_ni(rst_n_int), .bus_wr(bus_wr), .bus_addr(bus_addr),
  .run_q(run_q), .wcol_q(wcol_q), .spif_q(spif_q), .core_done(core_done),
  .core_active(core_active), .core_mid(core_mid), .sck_o(sck_o), .ctrl_q(ctrl_q)
);

// File: tb/tb_spi_port.sv
`timescale 1ns/1ps
module tb_spi_port;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bus_wr = 1'b0, bus_rd = 1'b0;
  logic [1:0] bus_addr = 2'd0;
  logic [7:0] bus_wdata = 8'h00;
  logic [7:0] bus_rdata;
  logic irq, sck_o, sck_oe, mosi_o, mosi_oe, miso_o, miso_oe;
  logic miso_i = 1'b0, sck_i = 1'b0, ss_n_i = 1'b1, mosi_i = 1'b0;

  int n_chk = 0, n_bad = 0;
  logic [7:0] exp_q[$];
  string      tag_q[$];

  always #4 clk = ~clk;

  spi_port dut (.*);

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // monitor: compares every data-register read against the scoreboard
  always @(negedge clk) begin
    #2;
    if (bus_rd && bus_addr == 2'd2) begin
      if (exp_q.size() == 0) chk(0, "scoreboard empty", bus_rdata, 0);
      else begin
        automatic logic [7:0] e = exp_q.pop_front();
        automatic string t = tag_q.pop_front();
        chk(bus_rdata === e, t, bus_rdata, e);
      end
    end
  end

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] v);
    @(negedge clk); bus_rd = 1'b1; bus_addr = a;
    #1 v = bus_rdata;
    @(negedge clk); bus_rd = 1'b0;
  endtask

  task automatic expect_rx(input logic [7:0] b, input string t);
    logic [7:0] dummy;
    exp_q.push_back(b); tag_q.push_back(t);
    rd(2'd2, dummy);
  endtask

  task automatic wait_done(output logic [7:0] st);
    st = 8'h00;
    for (int k = 0; k < 4000; k++) begin
      rd(2'd1, st);
      if (st[7]) break;
    end
  endtask

  task automatic wait_lead(input bit cpol);
    if (!cpol) @(posedge sck_o); else @(negedge sck_o);
  endtask
  task automatic wait_trail(input bit cpol);
    if (!cpol) @(negedge sck_o); else @(posedge sck_o);
  endtask

  // far-end slave for master-role tests
  task automatic slave_emul(input bit cpol, input bit cpha, input bit lsb,
                            input logic [7:0] tx, output logic [7:0] rx, output int per);
    time t1 = 0;
    rx = 8'h00; per = 0;
    if (!cpha) miso_i = lsb ? tx[0] : tx[7];
    for (int i = 0; i < 8; i++) begin
      automatic int b = lsb ? i : 7 - i;
      automatic int nb = lsb ? i + 1 : 6 - i;
      wait_lead(cpol);
      if (i == 0) t1 = $time;
      if (i == 1) per = int'(($time - t1) / 8);
      if (!cpha) rx[b] = mosi_o; else miso_i = tx[b];
      wait_trail(cpol);
      if (!cpha) begin if (i < 7) miso_i = tx[nb]; end
      else rx[b] = mosi_o;
    end
  endtask

  // far-end master for slave-role tests, half period of 8 clocks
  task automatic half_wait(); repeat (8) @(negedge clk); endtask
  task automatic master_emul(input bit cpol, input bit cpha, input bit lsb, input int nbits,
                             input logic [7:0] tx, output logic [7:0] rx, output bit oe_seen);
    rx = 8'h00;
    @(negedge clk); sck_i = cpol; ss_n_i = 1'b0;
    half_wait();
    oe_seen = miso_oe;
    for (int i = 0; i < nbits; i++) begin
      automatic int b = lsb ? i : 7 - i;
      if (!cpha) begin
        mosi_i = tx[b]; half_wait();
        sck_i = !cpol; rx[b] = miso_o; half_wait();
        sck_i = cpol;
      end else begin
        sck_i = !cpol; mosi_i = tx[b]; half_wait();
        sck_i = cpol; rx[b] = miso_o; half_wait();
      end
    end
    half_wait(); ss_n_i = 1'b1; half_wait();
  endtask

  task automatic master_case(input logic [7:0] ctrl, input logic [7:0] tx,
                             input logic [7:0] stx, input int exp_per, input string tag);
    logic [7:0] got, st; int per;
    wr(2'd0, ctrl);
    repeat (4) @(negedge clk);
    fork
      slave_emul(ctrl[2], ctrl[3], ctrl[4], stx, got, per);
      wr(2'd2, tx);
    join
    wait_done(st);
    chk(got === tx, {tag, " R1 R3 bytes seen by far end"}, got, tx);
    chk(per == exp_per, {tag, " R4 SCK period"}, per, exp_per);
    chk(st === 8'h80, {tag, " R1 done flag"}, st, 8'h80);
    chk(sck_o === ctrl[2], {tag, " R2 idle level after burst"}, sck_o, ctrl[2]);
    expect_rx(stx, {tag, " R1 R2 received byte"});
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    chk(0, "watchdog", 0, 1);
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [7:0] v, st, got;
    int per;
    bit oe;
    repeat (3) @(negedge clk); rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R9 R10 R7 reset state
    rd(2'd0, v); chk(v === 8'h00, "R9 control after reset", v, 0);
    rd(2'd1, v); chk(v === 8'h00, "R9 status after reset", v, 0);
    chk(irq === 1'b0, "R7 irq after reset", irq, 0);
    chk({sck_oe, mosi_oe, miso_oe} === 3'b000, "R10 enables after reset", {sck_oe, mosi_oe, miso_oe}, 0);

    // R1..R4 master in all four timing modes and all four rates
    master_case(8'h03, 8'hA5, 8'hC3, 4,   "mode0 msb div4");
    master_case(8'h3F, 8'h1E, 8'h4B, 16,  "mode3 lsb div16");
    master_case(8'h4B, 8'h69, 8'hF0, 64,  "mode1 msb div64");
    master_case(8'h77, 8'h0F, 8'h55, 128, "mode2 lsb div128");

    // R5 R7 collision during a master transfer
    wr(2'd0, 8'h83);
    repeat (4) @(negedge clk);
    fork
      slave_emul(1'b0, 1'b0, 1'b0, 8'hAA, got, per);
      begin
        wr(2'd2, 8'h33);
        repeat (10) @(negedge clk);
        wr(2'd2, 8'hFF);
        repeat (2) @(negedge clk);
        chk(irq === 1'b0, "R7 collision alone gives no irq", irq, 0);
      end
    join
    repeat (4) @(negedge clk);
    chk(irq === 1'b1, "R7 irq with done and enable", irq, 1);
    chk(got === 8'h33, "R5 shifted byte unchanged by colliding write", got, 8'h33);
    rd(2'd1, st); chk(st === 8'hC0, "R5 collision and done flags", st, 8'hC0);
    expect_rx(8'hAA, "R5 received byte");
    rd(2'd1, st); chk(st === 8'h00, "R8 flags cleared by status then data", st, 0);

    // R8 data access without a prior status read keeps the flags
    fork
      slave_emul(1'b0, 1'b0, 1'b0, 8'h34, got, per);
      wr(2'd2, 8'h12);
    join
    while (irq !== 1'b1) @(negedge clk);
    expect_rx(8'h34, "R8 received byte");
    rd(2'd1, st); chk(st === 8'h80, "R8 flag kept without status read", st, 8'h80);
    expect_rx(8'h34, "R8 data read after status");
    rd(2'd1, st); chk(st === 8'h00, "R8 flag cleared", st, 0);
    chk(irq === 1'b0, "R7 irq drops with flag", irq, 0);

    // R11 slave mode 0, MSB first
    wr(2'd0, 8'h01);
    wr(2'd2, 8'h5A);
    master_emul(1'b0, 1'b0, 1'b0, 8, 8'h96, got, oe);
    chk(oe === 1'b1, "R11 MISO driven while selected", oe, 1);
    chk(got === 8'h5A, "R11 slave transmit", got, 8'h5A);
    wait_done(st); chk(st === 8'h80, "R11 slave done flag", st, 8'h80);
    expect_rx(8'h96, "R11 slave receive");

    // R11 R3 slave mode 3, LSB first
    wr(2'd0, 8'h1D);
    repeat (4) @(negedge clk);
    wr(2'd2, 8'hC7);
    master_emul(1'b1, 1'b1, 1'b1, 8, 8'h2D, got, oe);
    chk(got === 8'hC7, "R11 R3 slave transmit lsb", got, 8'hC7);
    wait_done(st);
    expect_rx(8'h2D, "R11 R3 slave receive lsb");

    // R6 partial byte then deselect
    wr(2'd0, 8'h01);
    repeat (4) @(negedge clk);
    wr(2'd2, 8'h11);
    master_emul(1'b0, 1'b0, 1'b0, 3, 8'hFF, got, oe);
    repeat (5) @(negedge clk);
    chk(miso_oe === 1'b0, "R6 MISO released when deselected", miso_oe, 0);
    rd(2'd1, st); chk(st === 8'h00, "R6 partial byte sets no flag", st, 0);
    wr(2'd2, 8'h77);
    master_emul(1'b0, 1'b0, 1'b0, 8, 8'hE1, got, oe);
    chk(got === 8'h77, "R6 next byte aligned", got, 8'h77);
    wait_done(st); chk(st === 8'h80, "R6 full byte done, no collision", st, 8'h80);
    expect_rx(8'hE1, "R6 receive after rewind");

    // R10 disabled port
    wr(2'd0, 8'h02);
    wr(2'd2, 8'h44);
    repeat (300) @(negedge clk);
    chk({sck_oe, mosi_oe, miso_oe} === 3'b000, "R10 enables low when disabled", {sck_oe, mosi_oe, miso_oe}, 0);
    rd(2'd1, st); chk(st === 8'h00, "R10 no transfer when disabled", st, 0);

    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule